// File: doc/BRIEF.md
# Dual-Load Write-Through Level-1 Data Cache

This block is a first-level data cache that answers two loads in the same clock cycle and accepts one store per cycle. It holds 8 KB of data in 32-byte lines, direct-mapped and physically addressed. Each address selects exactly one line, so a single tag compare per access decides hit or miss. When a load misses, the controller asks the next level for the whole line. The words come back one per beat, and the line is installed after the last word arrives.

Stores are passed to the next level in the same cycle they arrive, so lines are never dirty. A store that hits also merges its enabled bytes into the cached word. A store that misses does not allocate a line. An enclosing inclusive cache can remove a line through the invalidate input. If both load ports miss on different lines, the two lines are fetched one after the other, port 0's first. Neither port is answered until both have their data.

Top module: `dcache_dualrd`

## Requirements
- R1: After reset every line is invalid. No load is answered before its line has been fetched, and `nl_rd_req` is low while no load is pending.
- R2: An address splits into bits [4:0] as line offset, bits [12:5] as line index and bits [31:13] as tag. A load returns the aligned 32-bit word selected by bits [31:2]. Lines whose index differs stay resident together.
- R3: When both ports present loads that hit, both are answered (`ld_ready` = 2'b11) in the same cycle, with no added delay.
- R4: A load miss raises `nl_rd_req` for one cycle with a line-aligned `nl_rd_addr` (bits [4:0] zero). The line is filled from 8 beats, in word order 0 to 7. The load is answered in the cycle after the last beat.
- R5: If both ports miss on different lines, port 0's line is requested first and port 1's line second, and both ports are answered together only after the second fill. If both ports miss on the same line, only one fill is made.
- R6: Every store, hit or miss, appears on `nl_wr_valid`/`nl_wr_addr`/`nl_wr_data`/`nl_wr_be` in the same cycle with identical values.
- R7: A store hit replaces only the bytes whose `st_be` bit is set (bit i covers data bits [8i+7:8i]), and loads see the result from the next cycle. A load of another line in the same cycle is unaffected.
- R8: A store miss requests no line, and a later load of that line still misses and returns the stored data fetched from the next level.
- R9: An invalidate whose tag matches the resident line makes that line miss from the following cycle on. An invalidate with a different tag at the same index has no effect.
- R10: Two addresses with the same index and different tags evict each other, so each reload after a conflict is a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 2 | Load request per port, held until answered |
| ld_addr0 | input | 32 | Port 0 load byte address |
| ld_addr1 | input | 32 | Port 1 load byte address |
| ld_ready | output | 2 | Load answered this cycle, per port |
| ld_data0 | output | 32 | Port 0 load word |
| ld_data1 | output | 32 | Port 1 load word |
| st_valid | input | 1 | Store request |
| st_addr | input | 32 | Store byte address |
| st_data | input | 32 | Store word |
| st_be | input | 4 | Store byte enables |
| inv_valid | input | 1 | Line invalidate request |
| inv_addr | input | 32 | Address of the line to invalidate |
| nl_rd_req | output | 1 | Line fetch request pulse |
| nl_rd_addr | output | 32 | Line-aligned fetch address |
| nl_rd_beat | input | 1 | Fill word valid |
| nl_rd_data | input | 32 | Fill word |
| nl_wr_valid | output | 1 | Forwarded store valid |
| nl_wr_addr | output | 32 | Forwarded store address |
| nl_wr_data | output | 32 | Forwarded store word |
| nl_wr_be | output | 4 | Forwarded store byte enables |

## Verification
The bench goes after the orderings that a port-blind or count-blind controller gets wrong. When both ports miss on different lines, a wrong design would fetch the lines in the wrong order, answer port 0 before port 1, or fetch a shared line twice. A fill whose beat count is off would return a shifted or stale word for some offset. A wrong address split would either keep two conflicting tags resident at once or evict lines whose index differs. The bench also sweeps every byte-enable pattern, where a merge error would corrupt neighbouring bytes. It issues store misses that would wrongly allocate a line, and invalidates with a mismatched tag that would wrongly drop a resident line.

// File: rtl/dc_pkg.sv
`timescale 1ns/1ps
package dc_pkg;
  localparam int DC_AW    = 32;
  localparam int DC_DW    = 32;
  localparam int DC_OFF_W = 5;
  localparam int DC_IDX_W = 8;

  typedef enum logic {RF_IDLE, RF_FILL} rf_state_e;
endpackage

// File: rtl/dc_tag_store.sv
`timescale 1ns/1ps
module dc_tag_store #(
  parameter int AW    = dc_pkg::DC_AW,
  parameter int OFF_W = dc_pkg::DC_OFF_W,
  parameter int IDX_W = dc_pkg::DC_IDX_W,
  parameter int NLK   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NLK-1:0][AW-1:0]   lk_addr,
  output logic [NLK-1:0]           lk_hit,
  input  logic                     fill_start,
  input  logic                     fill_done,
  input  logic [AW-1:0]            fill_addr,
  input  logic                     inv_valid,
  input  logic [AW-1:0]            inv_addr
);
  localparam int TAG_W = AW - OFF_W - IDX_W;
  localparam int LINES = 2 ** IDX_W;

  function automatic logic [IDX_W-1:0] f_idx(input logic [AW-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] f_tag(input logic [AW-1:0] a);
    return a[AW-1 -: TAG_W];
  endfunction

  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] vld_q;

  // named events for the checks
  logic [IDX_W-1:0] inv_idx, fill_idx;
  logic             inv_match, fill_same_idx;
  assign inv_idx       = f_idx(inv_addr);
  assign fill_idx      = f_idx(fill_addr);
  assign inv_match     = inv_valid && vld_q[inv_idx] && (tag_q[inv_idx] == f_tag(inv_addr));
  assign fill_same_idx = (fill_start || fill_done) && (fill_idx == inv_idx);

  for (genvar g = 0; g < NLK; g++) begin : g_lookup
    assign lk_hit[g] = vld_q[f_idx(lk_addr[g])] &&
                       (tag_q[f_idx(lk_addr[g])] == f_tag(lk_addr[g]));
  end

  always_ff @(posedge clk) begin
    if (fill_start) tag_q[fill_idx] <= f_tag(fill_addr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      if (inv_match)  vld_q[inv_idx]  <= 1'b0;
      if (fill_start) vld_q[fill_idx] <= 1'b0;
      if (fill_done)  vld_q[fill_idx] <= 1'b1;
    end
  end

  a_r4_install_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> vld_q[$past(fill_idx)]);

  a_r9_inv_clears_line: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_match && !fill_same_idx) |=> !vld_q[$past(inv_idx)]);
endmodule

// File: rtl/dc_data_store.sv
`timescale 1ns/1ps
module dc_data_store #(
  parameter int AW    = dc_pkg::DC_AW,
  parameter int DW    = dc_pkg::DC_DW,
  parameter int OFF_W = dc_pkg::DC_OFF_W,
  parameter int IDX_W = dc_pkg::DC_IDX_W
) (
  input  logic              clk,
  input  logic [AW-1:0]     rd_addr0,
  input  logic [AW-1:0]     rd_addr1,
  output logic [DW-1:0]     rd_data0,
  output logic [DW-1:0]     rd_data1,
  input  logic              fill_we,
  input  logic [AW-1:0]     fill_addr,
  input  logic [DW-1:0]     fill_data,
  input  logic              st_we,
  input  logic [AW-1:0]     st_addr,
  input  logic [DW-1:0]     st_data,
  input  logic [DW/8-1:0]   st_be
);
  localparam int BYTES  = DW / 8;
  localparam int BSEL_W = $clog2(BYTES);
  localparam int WA_W   = OFF_W + IDX_W - BSEL_W;
  localparam int WORDS  = 2 ** WA_W;

  function automatic logic [WA_W-1:0] f_word(input logic [AW-1:0] a);
    return a[OFF_W + IDX_W - 1 : BSEL_W];
  endfunction

  function automatic logic [DW-1:0] f_merge(input logic [DW-1:0] old_w,
                                            input logic [DW-1:0] new_w,
                                            input logic [BYTES-1:0] be);
    logic [DW-1:0] r;
    r = old_w;
    for (int b = 0; b < BYTES; b++)
      if (be[b]) r[8*b +: 8] = new_w[8*b +: 8];
    return r;
  endfunction

  logic [DW-1:0] mem_q [WORDS];
  logic [DW-1:0] st_base;

  // a store landing on the word being filled overlays the fill word
  assign st_base = (fill_we && f_word(fill_addr) == f_word(st_addr)) ? fill_data
                                                                      : mem_q[f_word(st_addr)];

  always_ff @(posedge clk) begin
    if (fill_we) mem_q[f_word(fill_addr)] <= fill_data;
    if (st_we)   mem_q[f_word(st_addr)]   <= f_merge(st_base, st_data, st_be);
  end

  assign rd_data0 = mem_q[f_word(rd_addr0)];
  assign rd_data1 = mem_q[f_word(rd_addr1)];
endmodule

// File: rtl/dc_refill_ctrl.sv
`timescale 1ns/1ps
module dc_refill_ctrl #(
  parameter int AW     = dc_pkg::DC_AW,
  parameter int OFF_W  = dc_pkg::DC_OFF_W,
  parameter int BSEL_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    miss,
  input  logic [AW-1:0] miss_addr0,
  input  logic [AW-1:0] miss_addr1,
  input  logic          beat,
  output logic          busy,
  output logic          nl_rd_req,
  output logic [AW-1:0] nl_rd_addr,
  output logic          fill_start,
  output logic          fill_done,
  output logic [AW-1:0] install_addr,
  output logic          fill_we,
  output logic [AW-1:0] fill_word_addr
);
  import dc_pkg::*;
  localparam int WSEL_W = OFF_W - BSEL_W;
  localparam int BEATS  = 2 ** WSEL_W;

  function automatic logic [AW-1:0] f_line(input logic [AW-1:0] a);
    return {a[AW-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  rf_state_e         state_q;
  logic [AW-1:0]     line_q;
  logic [WSEL_W-1:0] cnt_q;
  logic [AW-1:0]     pick_line;
  logic              last_beat;

  // port 0 has priority when both miss
  assign pick_line  = miss[0] ? f_line(miss_addr0) : f_line(miss_addr1);
  assign busy       = (state_q == RF_FILL);
  assign nl_rd_req  = !busy && (|miss);
  assign nl_rd_addr = pick_line;
  assign fill_start = nl_rd_req;
  assign fill_we    = busy && beat;
  assign last_beat  = (cnt_q == WSEL_W'(BEATS - 1));
  assign fill_done  = fill_we && last_beat;
  assign install_addr   = busy ? line_q : pick_line;
  assign fill_word_addr = {line_q[AW-1:OFF_W], cnt_q, {BSEL_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RF_IDLE;
      line_q  <= '0;
      cnt_q   <= '0;
    end else if (nl_rd_req) begin
      state_q <= RF_FILL;
      line_q  <= pick_line;
      cnt_q   <= '0;
    end else if (fill_we) begin
      cnt_q <= cnt_q + 1'b1;
      if (last_beat) state_q <= RF_IDLE;
    end
  end

  a_r4_req_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    nl_rd_req |=> !nl_rd_req);

  a_r4_beat_only_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> busy);
endmodule

// File: rtl/dcache_dualrd.sv
`timescale 1ns/1ps
module dcache_dualrd #(
  parameter int AW    = dc_pkg::DC_AW,
  parameter int DW    = dc_pkg::DC_DW,
  parameter int OFF_W = dc_pkg::DC_OFF_W,
  parameter int IDX_W = dc_pkg::DC_IDX_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      ld_valid,
  input  logic [AW-1:0]   ld_addr0,
  input  logic [AW-1:0]   ld_addr1,
  output logic [1:0]      ld_ready,
  output logic [DW-1:0]   ld_data0,
  output logic [DW-1:0]   ld_data1,
  input  logic            st_valid,
  input  logic [AW-1:0]   st_addr,
  input  logic [DW-1:0]   st_data,
  input  logic [DW/8-1:0] st_be,
  input  logic            inv_valid,
  input  logic [AW-1:0]   inv_addr,
  output logic            nl_rd_req,
  output logic [AW-1:0]   nl_rd_addr,
  input  logic            nl_rd_beat,
  input  logic [DW-1:0]   nl_rd_data,
  output logic            nl_wr_valid,
  output logic [AW-1:0]   nl_wr_addr,
  output logic [DW-1:0]   nl_wr_data,
  output logic [DW/8-1:0] nl_wr_be
);
  localparam int BSEL_W = $clog2(DW / 8);

  logic [2:0]         hit;
  logic [1:0]         miss;
  logic               stall, busy, st_hit, st_on_fill, st_we;
  logic               fill_start, fill_done, fill_we;
  logic [AW-1:0]      install_addr, fill_word_addr;

  dc_tag_store #(.AW(AW), .OFF_W(OFF_W), .IDX_W(IDX_W), .NLK(3)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_addr({st_addr, ld_addr1, ld_addr0}), .lk_hit(hit),
    .fill_start(fill_start), .fill_done(fill_done), .fill_addr(install_addr),
    .inv_valid(inv_valid), .inv_addr(inv_addr));

  dc_refill_ctrl #(.AW(AW), .OFF_W(OFF_W), .BSEL_W(BSEL_W)) u_refill (
    .clk(clk), .rst_n(rst_n), .miss(miss),
    .miss_addr0(ld_addr0), .miss_addr1(ld_addr1), .beat(nl_rd_beat),
    .busy(busy), .nl_rd_req(nl_rd_req), .nl_rd_addr(nl_rd_addr),
    .fill_start(fill_start), .fill_done(fill_done), .install_addr(install_addr),
    .fill_we(fill_we), .fill_word_addr(fill_word_addr));

  dc_data_store #(.AW(AW), .DW(DW), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_data (
    .clk(clk), .rd_addr0(ld_addr0), .rd_addr1(ld_addr1),
    .rd_data0(ld_data0), .rd_data1(ld_data1),
    .fill_we(fill_we), .fill_addr(fill_word_addr), .fill_data(nl_rd_data),
    .st_we(st_we), .st_addr(st_addr), .st_data(st_data), .st_be(st_be));

  assign miss     = ld_valid & ~hit[1:0];
  assign stall    = |miss;
  assign ld_ready = ld_valid & hit[1:0] & {2{!stall}};

  // stores merge into a resident line or the line being filled; never allocate
  assign st_hit     = hit[2];
  assign st_on_fill = busy && (st_addr[AW-1:OFF_W] == install_addr[AW-1:OFF_W]);
  assign st_we      = st_valid && (st_hit || st_on_fill);

  assign nl_wr_valid = st_valid;
  assign nl_wr_addr  = st_addr;
  assign nl_wr_data  = st_data;
  assign nl_wr_be    = st_be;

  a_r3_ports_answer_together: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid == 2'b11 && ld_ready != 2'b00) |-> ld_ready == 2'b11);

  a_r1_no_answer_while_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_we && !fill_done) |-> ld_ready == 2'b00 || !stall);
endmodule

// File: tb/test_dcache_dualrd.sv
`timescale 1ns/1ps
module test_dcache_dualrd;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ld_valid = '0;
  logic [31:0] ld_addr0 = '0, ld_addr1 = '0;
  logic [1:0]  ld_ready;
  logic [31:0] ld_data0, ld_data1;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0, st_data = '0;
  logic [3:0]  st_be = '0;
  logic        inv_valid = 1'b0;
  logic [31:0] inv_addr = '0;
  logic        nl_rd_req;
  logic [31:0] nl_rd_addr;
  logic        nl_rd_beat = 1'b0;
  logic [31:0] nl_rd_data = '0;
  logic        nl_wr_valid;
  logic [31:0] nl_wr_addr, nl_wr_data;
  logic [3:0]  nl_wr_be;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] wmem [int unsigned];
  logic [31:0] req_log [16];
  int req_cnt = 0;

  always #2.5 clk = ~clk;

  dcache_dualrd i_dcache_dualrd (.*);

  function automatic logic [31:0] mword(input logic [31:0] a);
    int unsigned k = a >> 2;
    if (wmem.exists(k)) return wmem[k];
    return (a >> 2) * 32'h9E37_79B1 ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // behavioural next-level memory
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && nl_rd_req) begin
        logic [31:0] la;
        la = nl_rd_addr;
        if (req_cnt < 16) req_log[req_cnt] = la;
        req_cnt++;
        @(posedge clk);
        for (int b = 0; b < 8; b++) begin
          #1 nl_rd_beat = 1'b1; nl_rd_data = mword(la + 32'(b * 4));
          @(posedge clk);
        end
        #1 nl_rd_beat = 1'b0;
      end
    end
  end

  task automatic do_load(input logic [1:0] v, input logic [31:0] a0, input logic [31:0] a1,
                         output logic [31:0] d0, output logic [31:0] d1,
                         output int waits, output logic [1:0] rdy);
    @(posedge clk); #1 ld_valid = v; ld_addr0 = a0; ld_addr1 = a1;
    waits = 0;
    while (1) begin
      @(negedge clk);
      if (ld_ready != 2'b00 || waits > 60) break;
      waits++;
    end
    rdy = ld_ready; d0 = ld_data0; d1 = ld_data1;
    @(posedge clk); #1 ld_valid = 2'b00;
  endtask

  task automatic do_store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    logic [31:0] w;
    @(posedge clk); #1 st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
    @(negedge clk);
    chk(nl_wr_valid && nl_wr_addr == a && nl_wr_data == d && nl_wr_be == be,
        "R6 store forward", nl_wr_data, d);
    w = mword(a);
    for (int b = 0; b < 4; b++) if (be[b]) w[8*b +: 8] = d[8*b +: 8];
    wmem[a >> 2] = w;
    @(posedge clk); #1 st_valid = 1'b0;
  endtask

  task automatic do_inv(input logic [31:0] a);
    @(posedge clk); #1 inv_valid = 1'b1; inv_addr = a;
    @(posedge clk); #1 inv_valid = 1'b0;
  endtask

  task automatic load1(input logic [31:0] a, input int exp_waits, input string req);
    logic [31:0] d0, d1; int w; logic [1:0] r;
    do_load(2'b01, a, 32'h0, d0, d1, w, r);
    chk(w == exp_waits, req, 32'(w), 32'(exp_waits));
    chk(d0 == mword(a) && r == 2'b01, req, d0, mword(a));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  localparam logic [31:0] A = 32'h0001_0040, B = 32'h0002_0100, C = 32'h0003_0200,
                          D = 32'h0004_0300, E = 32'h0005_0400, F = 32'h0006_0400,
                          X = 32'h0007_0800, Y = 32'h0007_1800, G = 32'h0008_0A00;

  initial begin
    logic [31:0] d0, d1; int w; logic [1:0] r; int rc;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(ld_ready == 2'b00 && !nl_rd_req, "R1 reset idle", {30'b0, ld_ready}, 32'h0);

    // R1/R4: cold miss, one aligned request, answered after 8 beats
    load1(A + 32'h8, 9, "R1 cold miss latency");
    chk(req_cnt == 1 && req_log[0] == A, "R4 aligned line request", req_log[0], A);

    // R4: every word of the filled line, through each port
    for (int i = 0; i < 8; i++) begin
      do_load(2'b01, A + 32'(4 * i), 32'h0, d0, d1, w, r);
      chk(w == 0 && d0 == mword(A + 32'(4 * i)), "R4 word order port0", d0, mword(A + 32'(4 * i)));
      do_load(2'b10, 32'h0, A + 32'(4 * i) + 32'h3, d0, d1, w, r);
      chk(w == 0 && r == 2'b10 && d1 == mword(A + 32'(4 * i)), "R4 word order port1", d1, mword(A + 32'(4 * i)));
    end

    // R3: two hits in one cycle
    for (int i = 0; i < 8; i++) begin
      do_load(2'b11, A + 32'(4 * i), A + 32'(4 * (7 - i)), d0, d1, w, r);
      chk(w == 0 && r == 2'b11, "R3 dual hit same cycle", {30'b0, r}, 32'h3);
      chk(d0 == mword(A + 32'(4 * i)) && d1 == mword(A + 32'(4 * (7 - i))), "R3 dual hit data", d1, mword(A + 32'(4 * (7 - i))));
    end

    // R5: both miss, different lines
    rc = req_cnt;
    do_load(2'b11, B + 32'h4, C + 32'h1C, d0, d1, w, r);
    chk(w == 18 && r == 2'b11, "R5 serial refills answered together", 32'(w), 32'd18);
    chk(req_cnt == rc + 2 && req_log[rc] == B && req_log[rc + 1] == C, "R5 port0 line first", req_log[rc], B);
    chk(d0 == mword(B + 32'h4) && d1 == mword(C + 32'h1C), "R5 data", d1, mword(C + 32'h1C));
    // R5: both miss on one line
    rc = req_cnt;
    do_load(2'b11, D, D + 32'h14, d0, d1, w, r);
    chk(w == 9 && req_cnt == rc + 1 && r == 2'b11, "R5 shared line single fill", 32'(req_cnt - rc), 32'd1);
    chk(d0 == mword(D) && d1 == mword(D + 32'h14), "R5 shared line data", d1, mword(D + 32'h14));

    // R2: different index stays resident; port1 alone may miss
    do_load(2'b10, 32'h0, X, d0, d1, w, r);
    chk(w == 9 && r == 2'b10 && d1 == mword(X), "R2 port1 miss", d1, mword(X));
    load1(Y, 9, "R2 second index miss");
    load1(X + 32'h10, 0, "R2 index kept resident");
    load1(Y + 32'h18, 0, "R2 index kept resident");

    // R10: same index, different tag
    load1(E, 9, "R10 first tag");
    load1(F, 9, "R10 conflicting tag");
    load1(E + 32'h4, 9, "R10 evicted reload");

    // R7: every byte-enable pattern on a resident word
    for (int be = 0; be < 16; be++) begin
      do_store(A + 32'h0C, 32'hA5C3_0000 + 32'(be * 32'h0101), 4'(be));
      load1(A + 32'h0C, 0, "R7 byte merge");
    end
    // R7: store hit concurrent with a load of another line
    @(posedge clk); #1 st_valid = 1'b1; st_addr = A + 32'h10; st_data = 32'hDEAD_BEEF; st_be = 4'hF;
    ld_valid = 2'b01; ld_addr0 = D + 32'h8;
    @(negedge clk);
    chk(ld_ready == 2'b01 && ld_data0 == mword(D + 32'h8), "R7 concurrent load unaffected", ld_data0, mword(D + 32'h8));
    wmem[(A + 32'h10) >> 2] = 32'hDEAD_BEEF;
    @(posedge clk); #1 st_valid = 1'b0; ld_valid = 2'b00;
    load1(A + 32'h10, 0, "R7 full word store");

    // R8: store miss does not allocate
    rc = req_cnt;
    do_store(G + 32'h8, 32'h1234_5678, 4'b0110);
    repeat (2) @(negedge clk);
    chk(req_cnt == rc, "R8 no fetch on store miss", 32'(req_cnt), 32'(rc));
    load1(G + 32'h8, 9, "R8 load after store miss");

    // R9: invalidate with other tag ignored, matching tag drops the line
    do_inv(F);
    load1(E + 32'h8, 0, "R9 mismatched tag ignored");
    do_inv(E + 32'h1C);
    load1(E + 32'h8, 9, "R9 matched invalidate");
    do_inv(A);
    load1(A + 32'h0C, 9, "R9 invalidate then refetch merged data");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule